// File: doc/BRIEF.md
# I2C Status Flag Controller

This block keeps the event status flags of an I2C peripheral and applies the rule that sets and clears each one. A separate byte engine sends it single-cycle strobes and level conditions. The strobes cover a byte leaving or landing in the holding register, a NACK, lost arbitration, a slave stop, start and stop conditions, and entry to master mode. The levels cover the address phase, byte-transfer-finished, next-byte-is-PEC and inside-a-byte. The block also watches the sampled SDA and SCL lines to detect bus errors.

Software reaches it through a small register port that selects the status word, the control word (interrupt enables) or the data register. A data register access has side effects on the flags but carries no data here, because the data path belongs to the byte engine. Each flag uses one of three ways to clear: writing zero to it, a side effect of a data register access, or a status read followed by a control write. While byte-transfer-finished is high, data accesses leave the holding flags alone. The outputs are the status word, a master-mode bit and a registered interrupt request.

Top module: `i2c_flag_ctrl`

## Requirements
- R1: After reset the status word, master bit and interrupt are 0. Status bit positions: stop-seen 4, rx-full 6, tx-empty 7, bus-error 8, arbitration-lost 9. All other bits, including bit 5, read 0. Register select codes: 0 status, 1 control, 2 data. `reg_rdata` shows the selected word without delay.
- R2: Arbitration-lost and bus-error clear only on a status write that carries 0 in their bit. A written 1 leaves them unchanged.
- R3: While `periph_en` is low, every flag and the master bit are held at 0, and event strobes have no effect.
- R4: An arbitration-lost strobe sets bit 9 and clears the master bit in the same cycle. `ev_master_start` sets the master bit.
- R5: Bus-error sets when `lv_in_byte` is high, SCL is high in both the previous and the current sample, and SDA changes. SDA changes while SCL is low, or outside a byte, do not set it.
- R6: Tx-empty sets on `ev_tx_empty` unless one of these holds: the address phase level is high, a NACK arrives in that cycle, a NACK has arrived since the last start, or the next byte is PEC.
- R7: A start or stop condition clears tx-empty. A data write also clears it, except for the first data write after a start and any data write while byte-transfer-finished is high.
- R8: Rx-full sets on `ev_rx_full`, but not during the address phase and not together with an arbitration-lost strobe. A data read or write clears it unless byte-transfer-finished is high.
- R9: Stop-seen sets on `ev_slave_stop` unless a NACK arrived in that cycle or since the last start. It clears only on a control write that comes after a status read. That control write also disarms the pending clear.
- R10: When a hardware set and a software clear of the same flag fall in one cycle, the flag ends up set.
- R11: `irq` is the OR of each flag ANDed with its enable, and lags the flags by one clock. The enable for a flag sits in the control word at the flag's own bit position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| periph_en | input | 1 | Peripheral enable; low forces flags to 0 |
| ev_tx_empty | input | 1 | Strobe: transmit holding register emptied |
| ev_rx_full | input | 1 | Strobe: receive holding register filled |
| ev_nack | input | 1 | Strobe: NACK received |
| ev_arb_lost | input | 1 | Strobe: arbitration lost |
| ev_slave_stop | input | 1 | Strobe: stop seen by slave after its acknowledge |
| ev_start_cond | input | 1 | Strobe: start condition on the bus |
| ev_stop_cond | input | 1 | Strobe: stop condition on the bus |
| ev_master_start | input | 1 | Strobe: engine entered master mode |
| lv_addr_phase | input | 1 | Level: address phase in progress |
| lv_btf | input | 1 | Level: byte-transfer-finished |
| lv_next_pec | input | 1 | Level: next byte to send is PEC |
| lv_in_byte | input | 1 | Level: inside a byte where start/stop is illegal |
| sda_in | input | 1 | Sampled SDA line |
| scl_in | input | 1 | Sampled SCL line |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 2 | Register select (0 status, 1 control, 2 data) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected register |
| status | output | 16 | Status word |
| master | output | 1 | Master-mode status |
| irq | output | 1 | Registered interrupt request |

## Verification
The hardest conditions to reach from the ports depend on history held inside the block. Examples are a tx-empty that survives a data write because that write was the first after a start, a stop-seen flag that a NACK several cycles earlier still suppresses, and a control write that clears stop-seen only because a status read came before it. The stimulus reaches these by running full orderings through the ports: a start, then a refill, then data writes with and without byte-transfer-finished; a NACK followed by later events; and a control write both before and after a status read. Set-versus-clear collisions are forced by driving a strobe and the matching register access in the same cycle. A behavioural model tracks every clock.

// File: rtl/i2cf_pkg.sv
// Shared constants for the I2C status flag controller.
// Assumes a status word at least 10 bits wide.
package i2cf_pkg;
    localparam int NUM_FLAGS = 5;
    localparam int F_STOP = 0;
    localparam int F_RXNE = 1;
    localparam int F_TXE  = 2;
    localparam int F_BERR = 3;
    localparam int F_ARB  = 4;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_CTRL   = 2'd1,
        SEL_DATA   = 2'd2
    } reg_sel_e;

    // Bit position of each flag in the status and control words
    function automatic int flag_pos(input int idx);
        case (idx)
            F_STOP:  return 4;
            F_RXNE:  return 6;
            F_TXE:   return 7;
            F_BERR:  return 8;
            default: return 9;
        endcase
    endfunction
endpackage

// File: rtl/i2cf_buserr_det.sv
// Bus error detector: flags an SDA edge seen while SCL stays high
// inside a byte. Assumes sda/scl are already synchronised.
module i2cf_buserr_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sda,
    input  logic scl,
    input  logic in_byte,
    output logic err
);
    logic sda_q, scl_q;

    // Keep last line samples; idle bus level is high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sda_q <= 1'b1;
            scl_q <= 1'b1;
        end else begin
            sda_q <= sda;
            scl_q <= scl;
        end
    end

    // SDA toggle with SCL high on both samples
    assign err = in_byte & scl_q & scl & (sda ^ sda_q);
endmodule

// File: rtl/i2cf_flag_cell.sv
// One status flag: set has priority over clear, enable low forces 0.
// Assumes set/clr are single-cycle qualified requests.
module i2cf_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic set_i,
    input  logic clr_i,
    output logic q
);
    // Flag state update
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= 1'b0;
        else if (!en)    q <= 1'b0;
        else if (set_i)  q <= 1'b1;
        else if (clr_i)  q <= 1'b0;
    end
endmodule

// File: rtl/i2cf_irq_gen.sv
// Interrupt request: OR of enabled flags, registered once.
// Assumes flags and enables share indices.
module i2cf_irq_gen #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] flags,
    input  logic [N-1:0] ie,
    output logic         irq
);
    // Register the gated OR
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |(flags & ie);
    end
endmodule

// File: rtl/i2c_flag_ctrl.sv
// I2C status flag controller top. Decodes register accesses, derives
// set/clear requests per flag, tracks start/NACK/arm/master state.
// Assumes event strobes are one cycle wide and WORD_W >= 10.
module i2c_flag_ctrl
    import i2cf_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              periph_en,
    input  logic              ev_tx_empty,
    input  logic              ev_rx_full,
    input  logic              ev_nack,
    input  logic              ev_arb_lost,
    input  logic              ev_slave_stop,
    input  logic              ev_start_cond,
    input  logic              ev_stop_cond,
    input  logic              ev_master_start,
    input  logic              lv_addr_phase,
    input  logic              lv_btf,
    input  logic              lv_next_pec,
    input  logic              lv_in_byte,
    input  logic              sda_in,
    input  logic              scl_in,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_sel,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic [WORD_W-1:0] status,
    output logic              master,
    output logic              irq
);
    localparam int NF = NUM_FLAGS;

    logic st_wr, st_rd, ctrl_wr, dat_wr, dat_rd;
    logic first_q, nack_q, armed_q, master_q, berr_ev;
    logic [NF-1:0] set_v, clr_v, flag_q, ie_q;
    logic [WORD_W-1:0] ctrl_word;
    logic unused_wbits;

    assign unused_wbits = ^reg_wdata;

    // Register access decode
    always_comb begin
        st_wr   = reg_wr && (reg_sel == SEL_STATUS);
        st_rd   = reg_rd && (reg_sel == SEL_STATUS);
        ctrl_wr = reg_wr && (reg_sel == SEL_CTRL);
        dat_wr  = reg_wr && (reg_sel == SEL_DATA);
        dat_rd  = reg_rd && (reg_sel == SEL_DATA);
    end

    i2cf_buserr_det u_berr (
        .clk     (clk),
        .rst_n   (rst_n),
        .sda     (sda_in),
        .scl     (scl_in),
        .in_byte (lv_in_byte),
        .err     (berr_ev)
    );

    // Per-flag set and clear requests
    always_comb begin
        set_v[F_STOP] = ev_slave_stop & ~ev_nack & ~nack_q;
        clr_v[F_STOP] = ctrl_wr & armed_q;
        set_v[F_RXNE] = ev_rx_full & ~lv_addr_phase & ~ev_arb_lost;
        clr_v[F_RXNE] = (dat_wr | dat_rd) & ~lv_btf;
        set_v[F_TXE]  = ev_tx_empty & ~lv_addr_phase & ~ev_nack & ~nack_q & ~lv_next_pec;
        clr_v[F_TXE]  = ev_start_cond | ev_stop_cond | (dat_wr & ~lv_btf & ~first_q);
        set_v[F_BERR] = berr_ev;
        clr_v[F_BERR] = st_wr & ~reg_wdata[flag_pos(F_BERR)];
        set_v[F_ARB]  = ev_arb_lost;
        clr_v[F_ARB]  = st_wr & ~reg_wdata[flag_pos(F_ARB)];
    end

    for (genvar i = 0; i < NF; i++) begin : g_flag
        i2cf_flag_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (periph_en),
            .set_i (set_v[i]),
            .clr_i (clr_v[i]),
            .q     (flag_q[i])
        );
    end

    // Sequencing state: first byte, NACK seen, clear armed, master mode
    always_ff @(posedge clk) begin
        if (!rst_n || !periph_en) begin
            first_q  <= 1'b0;
            nack_q   <= 1'b0;
            armed_q  <= 1'b0;
            master_q <= 1'b0;
        end else begin
            if (ev_start_cond)  first_q <= 1'b1;
            else if (dat_wr)    first_q <= 1'b0;
            if (ev_start_cond)  nack_q <= 1'b0;
            else if (ev_nack)   nack_q <= 1'b1;
            if (ctrl_wr)        armed_q <= 1'b0;
            else if (st_rd)     armed_q <= 1'b1;
            if (ev_arb_lost)          master_q <= 1'b0;
            else if (ev_master_start) master_q <= 1'b1;
        end
    end

    // Interrupt enable capture from control writes
    always_ff @(posedge clk) begin
        if (!rst_n) ie_q <= '0;
        else if (ctrl_wr) begin
            for (int i = 0; i < NF; i++) ie_q[i] <= reg_wdata[flag_pos(i)];
        end
    end

    // Place flags and enables at their word positions
    always_comb begin
        status    = '0;
        ctrl_word = '0;
        for (int i = 0; i < NF; i++) begin
            status[flag_pos(i)]    = flag_q[i];
            ctrl_word[flag_pos(i)] = ie_q[i];
        end
    end

    // Read data mux
    always_comb begin
        case (reg_sel)
            SEL_STATUS: reg_rdata = status;
            SEL_CTRL:   reg_rdata = ctrl_word;
            default:    reg_rdata = '0;
        endcase
    end

    assign master = master_q;

    i2cf_irq_gen #(.N(NF)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .flags (flag_q),
        .ie    (ie_q),
        .irq   (irq)
    );
endmodule

// File: rtl/i2cf_checker.sv
// Property checker for i2c_flag_ctrl, attached by bind.
module i2cf_checker #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              periph_en,
    input logic              ev_arb_lost,
    input logic              lv_btf,
    input logic              reg_wr,
    input logic [1:0]        reg_sel,
    input logic [WORD_W-1:0] reg_wdata,
    input logic [WORD_W-1:0] status,
    input logic              master,
    input logic              irq
);
    a_r2_arb_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_en && status[9] && !(reg_wr && reg_sel == 2'd0 && !reg_wdata[9])) |=> status[9]);

    a_r3_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !periph_en |=> (status == '0) && !master);

    a_r4_arb_drops_master: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_en && ev_arb_lost) |=> status[9] && !master);

    a_r8_rxne_btf_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_en && status[6] && lv_btf) |=> status[6]);

    a_r9_stop_needs_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_en && status[4] && !(reg_wr && reg_sel == 2'd1)) |=> status[4]);

    a_r11_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (status == '0) |=> !irq);
endmodule

bind i2c_flag_ctrl i2cf_checker #(.WORD_W(WORD_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .periph_en   (periph_en),
    .ev_arb_lost (ev_arb_lost),
    .lv_btf      (lv_btf),
    .reg_wr      (reg_wr),
    .reg_sel     (reg_sel),
    .reg_wdata   (reg_wdata),
    .status      (status),
    .master      (master),
    .irq         (irq)
);

// File: tb/i2c_flag_ctrl_test.sv
`timescale 1ns/1ps
module i2c_flag_ctrl_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic periph_en = 1'b0;
    logic ev_tx_empty = 0, ev_rx_full = 0, ev_nack = 0, ev_arb_lost = 0;
    logic ev_slave_stop = 0, ev_start_cond = 0, ev_stop_cond = 0, ev_master_start = 0;
    logic lv_addr_phase = 0, lv_btf = 0, lv_next_pec = 0, lv_in_byte = 0;
    logic sda_in = 1, scl_in = 1;
    logic reg_wr = 0, reg_rd = 0;
    logic [1:0] reg_sel = 2'd0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata, status;
    logic master, irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    i2c_flag_ctrl uut (.*);

    // Behavioural reference state
    logic [15:0] m_st, m_ie;
    logic m_master, m_irq, m_first, m_nack, m_armed, m_sda, m_scl;

    always @(posedge clk) begin
        bit stw, str, cw, dw, dr, be;
        logic [15:0] nx;
        if (!rst_n) begin
            m_st = 0; m_ie = 0; m_master = 0; m_irq = 0;
            m_first = 0; m_nack = 0; m_armed = 0; m_sda = 1; m_scl = 1;
        end else begin
            stw = reg_wr && reg_sel == 0; str = reg_rd && reg_sel == 0;
            cw  = reg_wr && reg_sel == 1;
            dw  = reg_wr && reg_sel == 2; dr = reg_rd && reg_sel == 2;
            be  = lv_in_byte && m_scl && scl_in && (sda_in != m_sda);
            m_sda = sda_in; m_scl = scl_in;
            m_irq = |(m_st & m_ie);
            if (cw) m_ie = reg_wdata & 16'h03D0;
            nx = m_st;
            if (!periph_en) begin
                nx = 0; m_first = 0; m_nack = 0; m_armed = 0; m_master = 0;
            end else begin
                if (ev_arb_lost) nx[9] = 1; else if (stw && !reg_wdata[9]) nx[9] = 0;
                if (be) nx[8] = 1; else if (stw && !reg_wdata[8]) nx[8] = 0;
                if (ev_tx_empty && !lv_addr_phase && !ev_nack && !m_nack && !lv_next_pec) nx[7] = 1;
                else if (ev_start_cond || ev_stop_cond || (dw && !lv_btf && !m_first)) nx[7] = 0;
                if (ev_rx_full && !lv_addr_phase && !ev_arb_lost) nx[6] = 1;
                else if ((dw || dr) && !lv_btf) nx[6] = 0;
                if (ev_slave_stop && !ev_nack && !m_nack) nx[4] = 1;
                else if (cw && m_armed) nx[4] = 0;
                if (ev_start_cond) m_first = 1; else if (dw) m_first = 0;
                if (ev_start_cond) m_nack = 0; else if (ev_nack) m_nack = 1;
                if (cw) m_armed = 0; else if (str) m_armed = 1;
                if (ev_arb_lost) m_master = 0; else if (ev_master_start) m_master = 1;
            end
            m_st = nx;
        end
    end

    // Compare design against the model every clock, away from the edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (status !== m_st || master !== m_master || irq !== m_irq) begin
                errors++;
                $display("FAIL %s model: status=%h master=%b irq=%b expected %h %b %b",
                    (status[9] !== m_st[9] || master !== m_master) ? "R4" :
                    (status[8] !== m_st[8]) ? "R5" : (status[7] !== m_st[7]) ? "R6" :
                    (status[6] !== m_st[6]) ? "R8" : (status[4] !== m_st[4]) ? "R9" :
                    (irq !== m_irq) ? "R11" : "R1",
                    status, master, irq, m_st, m_master, m_irq);
            end
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Advance one clock and drop all strobes
    task automatic cyc();
        @(posedge clk); #2;
        ev_tx_empty = 0; ev_rx_full = 0; ev_nack = 0; ev_arb_lost = 0;
        ev_slave_stop = 0; ev_start_cond = 0; ev_stop_cond = 0; ev_master_start = 0;
        reg_wr = 0; reg_rd = 0;
    endtask

    task automatic wr(input logic [1:0] s, input logic [15:0] d);
        reg_wr = 1; reg_sel = s; reg_wdata = d;
    endtask

    task automatic rd(input logic [1:0] s);
        reg_rd = 1; reg_sel = s;
    endtask

    initial begin
        repeat (3) cyc();
        rst_n = 1;
        chk("R1 reset status", status, 16'h0);
        chk("R1 reset master", {15'b0, master}, 16'h0);
        chk("R1 reset irq", {15'b0, irq}, 16'h0);

        periph_en = 1; cyc();
        ev_master_start = 1; cyc();
        chk("R4 master set", {15'b0, master}, 16'h1);
        ev_arb_lost = 1; cyc();
        chk("R4 arb status", status, 16'h0200);
        chk("R4 arb clears master", {15'b0, master}, 16'h0);
        reg_sel = 0; #1;
        chk("R1 read status word", reg_rdata, 16'h0200);
        wr(0, 16'hFFFF); cyc();
        chk("R2 write one keeps", status, 16'h0200);
        wr(0, 16'hFDFF); cyc();
        chk("R2 write zero clears", status, 16'h0);

        lv_in_byte = 1; scl_in = 1; sda_in = 1; cyc();
        sda_in = 0; cyc();
        chk("R5 sda edge scl high", status, 16'h0100);
        wr(0, 16'h0); cyc();
        chk("R2 berr cleared", status, 16'h0);
        scl_in = 0; cyc();
        sda_in = 1; cyc();
        chk("R5 scl low no error", status, 16'h0);
        scl_in = 1; cyc();
        lv_in_byte = 0; sda_in = 0; cyc();
        chk("R5 outside byte no error", status, 16'h0);

        lv_addr_phase = 1; ev_tx_empty = 1; cyc();
        chk("R6 addr phase suppresses", status, 16'h0);
        lv_addr_phase = 0; lv_next_pec = 1; ev_tx_empty = 1; cyc();
        chk("R6 pec suppresses", status, 16'h0);
        lv_next_pec = 0; ev_tx_empty = 1; cyc();
        chk("R6 txe set", status, 16'h0080);

        ev_start_cond = 1; cyc();
        chk("R7 start clears txe", status, 16'h0);
        ev_tx_empty = 1; cyc();
        wr(2, 16'h55); cyc();
        chk("R7 first write keeps", status, 16'h0080);
        lv_btf = 1; wr(2, 16'h55); cyc();
        chk("R7 btf write keeps", status, 16'h0080);
        lv_btf = 0; wr(2, 16'h55); cyc();
        chk("R7 write clears", status, 16'h0);
        ev_nack = 1; cyc();
        ev_tx_empty = 1; cyc();
        chk("R6 after nack suppressed", status, 16'h0);
        ev_start_cond = 1; cyc();

        ev_rx_full = 1; cyc();
        chk("R8 rxne set", status, 16'h0040);
        lv_btf = 1; rd(2); cyc();
        chk("R8 btf read keeps", status, 16'h0040);
        lv_btf = 0; rd(2); cyc();
        chk("R8 read clears", status, 16'h0);
        ev_rx_full = 1; ev_arb_lost = 1; cyc();
        chk("R8 arb suppresses rxne", status, 16'h0200);
        wr(0, 16'h0); cyc();

        ev_slave_stop = 1; cyc();
        chk("R9 stop set", status, 16'h0010);
        wr(1, 16'h0); cyc();
        chk("R9 ctrl write unarmed keeps", status, 16'h0010);
        rd(0); cyc();
        wr(1, 16'h0); cyc();
        chk("R9 read then write clears", status, 16'h0);
        ev_nack = 1; cyc();
        ev_slave_stop = 1; cyc();
        chk("R9 no stop after nack", status, 16'h0);
        ev_start_cond = 1; cyc();

        ev_arb_lost = 1; wr(0, 16'h0); cyc();
        chk("R10 arb set wins", status, 16'h0200);
        ev_rx_full = 1; rd(2); cyc();
        chk("R10 rxne set wins", status, 16'h0240);
        wr(0, 16'h0); cyc();
        rd(2); cyc();
        chk("R10 cleared after", status, 16'h0);

        wr(1, 16'h0040); cyc();
        ev_rx_full = 1; cyc();
        chk("R11 irq lags flag", {15'b0, irq}, 16'h0);
        cyc();
        chk("R11 irq asserted", {15'b0, irq}, 16'h1);
        ev_arb_lost = 1; cyc();
        rd(2); cyc();
        cyc();
        chk("R11 masked flag no irq", {15'b0, irq}, 16'h0);

        ev_master_start = 1; cyc();
        periph_en = 0; cyc();
        chk("R3 disable clears", status, 16'h0);
        chk("R3 disable clears master", {15'b0, master}, 16'h0);
        ev_rx_full = 1; ev_arb_lost = 1; cyc();
        chk("R3 events ignored", status, 16'h0);
        cyc();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule